// File: doc/BRIEF.md
# Dual-Port Pin Expander Register Bank

This block holds the configuration and state of sixteen general-purpose pins, grouped as two byte-wide ports. Pins 0 to 7 belong to port 0 and pins 8 to 15 belong to port 1, so a pin's port index is its number shifted right by three. A byte-wide register interface reaches the bank: an 8-bit address, 8-bit write data, a write strobe, and read data that follows the address combinationally. A serial-bus slave front end would sit in front of this interface.

Each pin has four stored settings: an output level, a direction, an interrupt-disable flag and a function select. The function select chooses general-purpose use or LED/PWM use. It is only stored and exported here. The bank turns the level and direction bits into a pad output value and a pad output enable for each pin. Port 0 can be switched between open-drain and push-pull drive by one bit of a global control register. Port 1 is always push-pull. Pad inputs pass through a synchronizer before they can be read back.

Two registers have special roles. One is a fixed identification register. The other is a reset register: writing zero to it returns every register to its default value.

Top module: `gpx_bank`

## Requirements
- R1: After reset, the registers hold these defaults: direction 0xFF on both ports, output level 0x00, interrupt disable 0xFF, function select 0xFF, and control 0x00. With these defaults every pad_oe bit is 0.
- R2: A pin whose direction bit is 1 is an input. Its pad_oe is 0 and its pad_out is 0. Direction bytes live at 0x04 (port 0) and 0x05 (port 1), and bit n of each byte maps to pin n of that port.
- R3: A pin whose direction bit is 0 is push-pull when it is on port 1, or on port 0 with control bit 4 set. Such a pin has pad_oe 1 and pad_out equal to its output-level bit. Output-level bytes live at 0x02 (port 0) and 0x03 (port 1).
- R4: A port-0 output pin with control bit 4 clear is open-drain. A level of 1 gives pad_oe 0, and a level of 0 gives pad_oe 1 with pad_out 0.
- R5: Reading 0x00 returns the port-0 pad levels, and reading 0x01 returns the port-1 pad levels. A pad level becomes readable two rising edges after it is applied, whatever the pin's direction. Writes to these two addresses have no effect.
- R6: Address 0x10 always reads 0x23. Writes to it have no effect.
- R7: The control register at 0x11 reads back the last byte written to it. Its bits 1:0 appear on drive_sel.
- R8: The function bytes at 0x12 (port 0) and 0x13 (port 1) read back as written and appear on pin_gpio, where 1 means general purpose and 0 means LED/PWM.
- R9: Writing 0x00 to 0x7F restores all R1 defaults on the next edge. Writing any other value to 0x7F changes nothing. Address 0x7F reads 0.
- R10: Addresses 0x08 to 0x0F and 0x14 to 0x7E read 0. Writes to them change no register and no output.
- R11: The interrupt-disable bytes at 0x06 (port 0) and 0x07 (port 1) read back as written and appear on irq_disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| pad_in | input | 16 | Raw pad input levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| pin_gpio | output | 16 | Per-pin function, 1 = general purpose |
| irq_disable | output | 16 | Per-pin interrupt-disable flags |
| drive_sel | output | 2 | Current-select field of the control register |

## Verification
The embedded assertions check a set of rules on every cycle. No input pin ever has its enable raised. On port 0 in open-drain mode the pad value stays low. Port-1 output pins always drive. A zero written to the reset register restores the defaults. A write to a hole, to the identification register or to the input registers leaves all stored state untouched.

Some behaviours need the bench's scenarios, because they compare against a model. These are the two-edge latency of input sampling, the exact read-back value of every address, and the level-dependent enable on open-drain pins. The bench also covers a nonzero write to the reset register and the interaction of random configurations with random pad levels.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   localparam logic [7:0] ADR_IDENT = 8'h10;
   localparam logic [7:0] ADR_CTRL  = 8'h11;
   localparam logic [7:0] ADR_FUNC  = 8'h12;
   localparam logic [7:0] ADR_SRST  = 8'h7F;
   localparam int         CTRL_PP_BIT = 4;

   typedef enum logic [2:0] {
      BK_HOLE, BK_IN, BK_LVL, BK_DIR, BK_IDIS, BK_IDENT, BK_CTRL, BK_FUNC
   } bank_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("gpx_sync needs at least two stages");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
   import gpx_pkg::*;
#(
   parameter int         NUM_PORTS = 2,
   parameter int         DW        = 8,
   parameter logic [7:0] ID_VALUE  = 8'h23,
   localparam int        NPINS     = NUM_PORTS * DW,
   localparam int        IW        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [7:0]       addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  logic [NPINS-1:0] in_sync,
   output logic [NPINS-1:0] lvl,
   output logic [NPINS-1:0] dir,
   output logic [NPINS-1:0] idis,
   output logic [NPINS-1:0] func,
   output logic             ctrl_pp,
   output logic [1:0]       ctrl_isel
);
   if (4 * NUM_PORTS > 16 || DW != 8) begin : g_bad
      $error("gpx_regfile: map supports up to 4 ports of 8 bits");
   end

   localparam int BASE_IN   = 0;
   localparam int BASE_LVL  = NUM_PORTS;
   localparam int BASE_DIR  = 2 * NUM_PORTS;
   localparam int BASE_IDIS = 3 * NUM_PORTS;

   logic [NUM_PORTS-1:0][DW-1:0] lvl_q, dir_q, idis_q, func_q, in_arr;
   logic [DW-1:0]                ctrl_q;
   bank_e                        bank;
   logic [IW-1:0]                idx;
   logic                         soft_rst;

   always_comb begin
      bank = BK_HOLE;
      idx  = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (addr == 8'(BASE_IN + p))   begin bank = BK_IN;   idx = IW'(p); end
         if (addr == 8'(BASE_LVL + p))  begin bank = BK_LVL;  idx = IW'(p); end
         if (addr == 8'(BASE_DIR + p))  begin bank = BK_DIR;  idx = IW'(p); end
         if (addr == 8'(BASE_IDIS + p)) begin bank = BK_IDIS; idx = IW'(p); end
         if (addr == ADR_FUNC + 8'(p))  begin bank = BK_FUNC; idx = IW'(p); end
      end
      if (addr == ADR_IDENT) bank = BK_IDENT;
      if (addr == ADR_CTRL)  bank = BK_CTRL;
   end

   assign soft_rst = wr && (addr == ADR_SRST) && (wdata == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= '0;
         dir_q  <= '1;
         idis_q <= '1;
         func_q <= '1;
         ctrl_q <= '0;
      end else if (soft_rst) begin
         lvl_q  <= '0;
         dir_q  <= '1;
         idis_q <= '1;
         func_q <= '1;
         ctrl_q <= '0;
      end else if (wr) begin
         case (bank)
            BK_LVL:  lvl_q[idx]  <= wdata;
            BK_DIR:  dir_q[idx]  <= wdata;
            BK_IDIS: idis_q[idx] <= wdata;
            BK_FUNC: func_q[idx] <= wdata;
            BK_CTRL: ctrl_q      <= wdata;
            default: ;
         endcase
      end
   end

   assign in_arr = in_sync;

   always_comb begin
      case (bank)
         BK_IN:    rdata = in_arr[idx];
         BK_LVL:   rdata = lvl_q[idx];
         BK_DIR:   rdata = dir_q[idx];
         BK_IDIS:  rdata = idis_q[idx];
         BK_FUNC:  rdata = func_q[idx];
         BK_IDENT: rdata = ID_VALUE;
         BK_CTRL:  rdata = ctrl_q;
         default:  rdata = '0;
      endcase
   end

   assign lvl       = lvl_q;
   assign dir       = dir_q;
   assign idis      = idis_q;
   assign func      = func_q;
   assign ctrl_pp   = ctrl_q[CTRL_PP_BIT];
   assign ctrl_isel = ctrl_q[1:0];

   assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (dir_q == '1 && lvl_q == '0 && idis_q == '1 && func_q == '1 && ctrl_q == '0));

   assert_hole_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bank == BK_HOLE && addr != ADR_SRST) |=>
         ($stable(lvl_q) && $stable(dir_q) && $stable(idis_q) && $stable(func_q) && $stable(ctrl_q)));

   assert_ident_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (bank == BK_IDENT || bank == BK_IN)) |=>
         ($stable(lvl_q) && $stable(dir_q) && $stable(idis_q) && $stable(func_q) && $stable(ctrl_q)));
endmodule

// File: rtl/gpx_pad_drive.sv
module gpx_pad_drive #(
   parameter int NUM_PORTS = 2,
   parameter int DW        = 8,
   parameter int OD_PORTS  = 1,
   localparam int NPINS    = NUM_PORTS * DW
) (
   input  logic [NPINS-1:0] lvl,
   input  logic [NPINS-1:0] dir,
   input  logic             ctrl_pp,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe
);
   if (OD_PORTS > NUM_PORTS) begin : g_bad
      $error("gpx_pad_drive: more open-drain ports than ports");
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [DW-1:0] l, d;
      assign l = lvl[p*DW +: DW];
      assign d = dir[p*DW +: DW];
      if (p < OD_PORTS) begin : g_od_capable
         assign pad_oe[p*DW +: DW]  = ~d & (ctrl_pp ? '1 : ~l);
         assign pad_out[p*DW +: DW] = ~d & (ctrl_pp ? l : '0);
      end else begin : g_push_pull
         assign pad_oe[p*DW +: DW]  = ~d;
         assign pad_out[p*DW +: DW] = ~d & l;
      end
   end
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank #(
   parameter int         NUM_PORTS   = 2,
   parameter int         DW          = 8,
   parameter int         OD_PORTS    = 1,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] ID_VALUE    = 8'h23,
   localparam int        NPINS       = NUM_PORTS * DW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [7:0]       reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] pin_gpio,
   output logic [NPINS-1:0] irq_disable,
   output logic [1:0]       drive_sel
);
   logic [NPINS-1:0] in_sync, lvl_w, dir_w;
   logic             ctrl_pp;

   gpx_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync));

   gpx_regfile #(.NUM_PORTS(NUM_PORTS), .DW(DW), .ID_VALUE(ID_VALUE)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .in_sync(in_sync), .lvl(lvl_w), .dir(dir_w),
      .idis(irq_disable), .func(pin_gpio), .ctrl_pp(ctrl_pp), .ctrl_isel(drive_sel));

   gpx_pad_drive #(.NUM_PORTS(NUM_PORTS), .DW(DW), .OD_PORTS(OD_PORTS)) u_drive (
      .lvl(lvl_w), .dir(dir_w), .ctrl_pp(ctrl_pp), .pad_out(pad_out), .pad_oe(pad_oe));

   assert_input_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_w & pad_oe) == '0);

   assert_od_never_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_pp |-> (pad_out[OD_PORTS*DW-1:0] == '0));

   assert_pp_port_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((~dir_w[NPINS-1:OD_PORTS*DW]) & ~pad_oe[NPINS-1:OD_PORTS*DW]) == '0);
endmodule

// File: tb/gpx_bank_bench.sv
module gpx_bank_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_out, pad_oe, pin_gpio, irq_disable;
   logic [1:0]  drive_sel;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpx_bank u_gpx_bank (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pin_gpio(pin_gpio),
      .irq_disable(irq_disable), .drive_sel(drive_sel));

   int nchk = 0, nerr = 0;
   bit done = 0;

   logic [15:0] m_lvl, m_dir, m_idis, m_func;
   logic [7:0]  m_ctrl;

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void model_defaults();
      m_lvl = '0; m_dir = '1; m_idis = '1; m_func = '1; m_ctrl = '0;
   endfunction

   function automatic void model_write(input logic [7:0] a, input logic [7:0] d);
      case (a)
         8'h02: m_lvl[7:0] = d;    8'h03: m_lvl[15:8] = d;
         8'h04: m_dir[7:0] = d;    8'h05: m_dir[15:8] = d;
         8'h06: m_idis[7:0] = d;   8'h07: m_idis[15:8] = d;
         8'h11: m_ctrl = d;
         8'h12: m_func[7:0] = d;   8'h13: m_func[15:8] = d;
         8'h7F: if (d == 8'h00) model_defaults();
         default: ;
      endcase
   endfunction

   function automatic logic [7:0] model_read(input logic [7:0] a);
      case (a)
         8'h00: return pad_in[7:0];   8'h01: return pad_in[15:8];
         8'h02: return m_lvl[7:0];    8'h03: return m_lvl[15:8];
         8'h04: return m_dir[7:0];    8'h05: return m_dir[15:8];
         8'h06: return m_idis[7:0];   8'h07: return m_idis[15:8];
         8'h10: return 8'h23;
         8'h11: return m_ctrl;
         8'h12: return m_func[7:0];   8'h13: return m_func[15:8];
         default: return 8'h00;
      endcase
   endfunction

   function automatic string tag_of(input logic [7:0] a);
      if (a <= 8'h01) return "R5";
      if (a <= 8'h05) return "R3";
      if (a <= 8'h07) return "R11";
      if (a == 8'h10) return "R6";
      if (a == 8'h11) return "R7";
      if (a <= 8'h13) return "R8";
      if (a == 8'h7F) return "R9";
      return "R10";
   endfunction

   function automatic logic [31:0] exp_pads();
      logic [15:0] oe, o;
      for (int i = 0; i < 16; i++) begin
         if (m_dir[i]) begin oe[i] = 0; o[i] = 0; end
         else if (i < 8 && !m_ctrl[4]) begin oe[i] = ~m_lvl[i]; o[i] = 0; end
         else begin oe[i] = 1; o[i] = m_lvl[i]; end
      end
      return {oe, o};
   endfunction

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0;
      model_write(a, d);
   endtask

   task automatic rd_chk(input logic [7:0] a, input string tag);
      reg_addr = a;
      #1;
      check({24'h0, reg_rdata}, {24'h0, model_read(a)}, tag);
   endtask

   task automatic chk_outputs(input string tag);
      check({pad_oe, pad_out}, exp_pads(), tag);
      check({pin_gpio, irq_disable}, {m_func, m_idis}, tag);
      check({30'h0, drive_sel}, {30'h0, m_ctrl[1:0]}, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      model_defaults();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset defaults
      for (int a = 0; a < 20; a++) rd_chk(8'(a), "R1");
      check({16'h0, pad_oe}, 32'h0, "R1");
      chk_outputs("R1");

      // R2/R5: input pins sample pads after two edges
      @(negedge clk); pad_in = 16'hA55A;
      @(negedge clk); @(negedge clk);
      rd_chk(8'h00, "R5"); rd_chk(8'h01, "R5");
      wr(8'h00, 8'hFF); wr(8'h01, 8'h00);
      chk_outputs("R5"); rd_chk(8'h00, "R5");

      // R4 open-drain port 0, R3 push-pull port 1
      wr(8'h02, 8'hF0); wr(8'h03, 8'h3C);
      wr(8'h04, 8'h00); wr(8'h05, 8'h0F);
      chk_outputs("R4");
      check({16'h0, pad_oe & 16'h00FF}, 32'h000F, "R4");
      // R5: output pins still read pad levels
      rd_chk(8'h00, "R5");
      wr(8'h11, 8'h13);
      chk_outputs("R3");
      check({16'h0, pad_out & 16'h00FF}, 32'h00F0, "R3");
      check({30'h0, drive_sel}, 32'h3, "R7");

      // R6 identification is read-only
      wr(8'h10, 8'h55); rd_chk(8'h10, "R6"); chk_outputs("R6");
      // R10 hole writes
      wr(8'h09, 8'hAA); wr(8'h40, 8'h00); wr(8'h7E, 8'h00);
      rd_chk(8'h09, "R10"); rd_chk(8'h40, "R10"); chk_outputs("R10");
      for (int a = 2; a < 8; a++) rd_chk(8'(a), "R10");
      // R8 / R11
      wr(8'h12, 8'h0F); wr(8'h13, 8'hE1); wr(8'h06, 8'h12); wr(8'h07, 8'h34);
      rd_chk(8'h12, "R8"); rd_chk(8'h13, "R8");
      rd_chk(8'h06, "R11"); rd_chk(8'h07, "R11"); chk_outputs("R8");
      // R9 nonzero write ignored, zero restores
      wr(8'h7F, 8'h01); chk_outputs("R9"); rd_chk(8'h04, "R9"); rd_chk(8'h7F, "R9");
      wr(8'h7F, 8'h00); chk_outputs("R9");
      for (int a = 2; a < 20; a++) rd_chk(8'(a), "R9");

      // constrained random mix
      for (int it = 0; it < 400; it++) begin
         logic [7:0] a, d;
         int c;
         c = int'($urandom % 10);
         case (c)
            0, 1, 2, 3: a = 8'($urandom % 8);
            4: a = 8'h10 + 8'($urandom % 4);
            5: a = 8'h08 + 8'($urandom % 8);
            6: a = 8'h14 + 8'($urandom % 107);
            7: a = 8'h7F;
            default: a = 8'h02 + 8'($urandom % 4);
         endcase
         d = 8'($urandom);
         if (a == 8'h7F && ($urandom % 2) == 0) d = 8'h00;
         wr(a, d);
         if (($urandom % 4) == 0) begin
            pad_in = 16'($urandom);
            @(negedge clk); @(negedge clk);
         end
         chk_outputs(tag_of(a));
         rd_chk(a, tag_of(a));
         rd_chk(8'($urandom % 20), "R5");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule